// File: doc/BRIEF.md
# Calendar and Time-of-Day Counter

This block keeps wall-clock time and date as a set of byte registers: seconds, minutes, hours, day of week, day of month, month, two-digit year, and a century byte with an identical mirror copy. Each pulse on the one-second tick input advances the count by one second. Carries ripple upward through the fields in the same cycle.

Two run-time controls shape the arithmetic. A data-mode input selects packed BCD, where each nibble is one decimal digit, or plain binary. A format input selects a 24-hour clock or a 12-hour clock with a PM flag in the hour byte. Month lengths come from a fixed non-leap table.

A host freezes the count by raising the hold input. While hold is high, it can preset any field through a select/data load port. When hold drops, counting resumes from the loaded values. Mode changes do not convert stored bytes, so the host reloads the fields after switching mode.

Top module: `rtc_calendar_counter`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day of month 0x01, month 0x01, year 0x08, and both century bytes 0x20.
- R2: With `bin_mode_i`=0 (packed BCD), a tick raises the low digit. A low digit of 9 returns to 0 and carries into the high digit. Seconds and minutes roll from 0x59 to 0x00 and carry into the next field.
- R3: With `bin_mode_i`=1 (binary), fields count in plain binary: 9 is followed by 0x0A, seconds and minutes roll from 59 to 0, and hours roll from 23 to 0.
- R4: With `h24_i`=1, the hour rolls from 23 to 0 on a minute carry. This rollover is the day carry.
- R5: With `h24_i`=0, bit 7 of the hour byte is a PM flag and the low seven bits hold 1 to 12. Advancing 11 AM gives 12 PM (0x92 in BCD). Advancing 11 PM gives 12 AM (0x12 in BCD) with a day carry.
- R6: On a day carry the weekday advances within 0 to 6, and 6 is followed by 0.
- R7: On a day carry the day of month advances. When it equals the month's length (31, with 30 for months 4, 6, 9 and 11, and 28 for month 2), it returns to 1 and the month advances.
- R8: Month 12 is followed by month 1 with a year step. Year 99 is followed by 0 with a century step. The two century bytes always hold the same value.
- R9: While `hold_i`=1, ticks have no effect. A load pulse with `hold_i`=0 changes nothing.
- R10: While `hold_i`=1, a `load_en_i` pulse writes `load_data_i` into the field chosen by `load_sel_i`: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 7 both century bytes. The loaded value is visible the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance pulse |
| bin_mode_i | input | 1 | 0 packed BCD, 1 binary |
| h24_i | input | 1 | 1 24-hour, 0 12-hour with PM flag |
| hold_i | input | 1 | Freeze count and enable loads |
| load_en_i | input | 1 | Load strobe |
| load_sel_i | input | 3 | Field select for load |
| load_data_i | input | 8 | Load value |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours (bit 7 PM in 12-hour format) |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| cent_o | output | 8 | Century |
| cent2_o | output | 8 | Century mirror |

## Verification
Every field is a register, so a tick sampled at a rising edge changes every affected field at that same edge. This includes a carry that reaches from seconds up to the century. A load strobe likewise shows up one edge later.

A behavioural model in the bench applies the same tick or load at the same rising edge. All nine outputs are compared against the model at the following falling edge, so each check sees exactly one cycle's worth of change.

Directed sequences preload a field just below each rollover point and then send single ticks, so each carry boundary is hit exactly once.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W = 8;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_MDAY = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6,
    FLD_CENT = 3'd7
  } fld_e;

  // decode a stored byte to its numeric value
  function automatic logic [FIELD_W-1:0] to_bin(logic [FIELD_W-1:0] b, logic bcd);
    logic [FIELD_W-1:0] hi, lo;
    hi = {4'd0, b[7:4]};
    lo = {4'd0, b[3:0]};
    return bcd ? ((hi << 3) + (hi << 1) + lo) : b;
  endfunction

  // encode a numeric value (below 100) in the selected representation
  function automatic logic [FIELD_W-1:0] from_bin(logic [FIELD_W-1:0] v, logic bcd);
    logic [FIELD_W-1:0] q, r;
    q = v / 8'd10;
    r = v - ((q << 3) + (q << 1));
    return bcd ? {q[3:0], r[3:0]} : v;
  endfunction

  // non-leap month length, numeric month in, numeric days out
  function automatic logic [FIELD_W-1:0] month_days(logic [FIELD_W-1:0] m);
    case (m)
      8'd2:                     return 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_step_field.sv
module rtc_step_field #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic         bcd_i,
  input  logic [W-1:0] first_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] next_o,
  output logic         wrap_o
);
  localparam int DIGITS = W / 4;

  logic [DIGITS-1:0] cy;
  logic [DIGITS-1:0] dig_wrap;
  logic [W-1:0]      bcd_inc;
  logic [W-1:0]      bin_inc;

  assign cy[0] = 1'b1;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign dig_wrap[d] = cy[d] & (cur_i[4*d +: 4] == 4'd9);
    assign bcd_inc[4*d +: 4] = dig_wrap[d] ? 4'd0 : (cur_i[4*d +: 4] + {3'd0, cy[d]});
    if (d < DIGITS - 1) begin : g_chain
      assign cy[d+1] = dig_wrap[d];
    end
  end

  assign bin_inc = cur_i + W'(1);
  assign wrap_o  = (cur_i == last_i);
  assign next_o  = wrap_o ? first_i : (bcd_i ? bcd_inc : bin_inc);
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic               bcd_i,
  input  logic               h24_i,
  input  logic               ld_go_i,
  input  fld_e               ld_sel_i,
  input  logic [FIELD_W-1:0] ld_data_i,
  output logic [FIELD_W-1:0] sec_o,
  output logic [FIELD_W-1:0] min_o,
  output logic [FIELD_W-1:0] hour_o,
  output logic               day_step_o
);
  logic [FIELD_W-1:0] sec_q, sec_d, min_q, min_d, hr_q, hr_d;
  logic [FIELD_W-1:0] sec_nx, min_nx, hr_nx;
  logic               sec_wrap, min_wrap, hr_wrap;
  logic [FIELD_W-1:0] last_60;
  logic [FIELD_W-1:0] hr_12raw, hr_12base, hr_num, hr_inc, hr_12val, hr_12enc;
  logic               hr_pm;

  assign last_60 = from_bin(8'd59, bcd_i);

  rtc_step_field #(.W(FIELD_W)) u_sec (
    .cur_i(sec_q), .bcd_i(bcd_i), .first_i('0), .last_i(last_60),
    .next_o(sec_nx), .wrap_o(sec_wrap));

  rtc_step_field #(.W(FIELD_W)) u_min (
    .cur_i(min_q), .bcd_i(bcd_i), .first_i('0), .last_i(last_60),
    .next_o(min_nx), .wrap_o(min_wrap));

  // hour: bring to a 0..23 number, step, re-encode in the active format
  always_comb begin
    hr_12raw  = to_bin({1'b0, hr_q[6:0]}, bcd_i);
    hr_12base = (hr_12raw == 8'd12) ? 8'd0 : hr_12raw;
    hr_num    = h24_i ? to_bin(hr_q, bcd_i) : (hr_12base + (hr_q[7] ? 8'd12 : 8'd0));
    hr_wrap   = (hr_num == 8'd23);
    hr_inc    = hr_wrap ? 8'd0 : hr_num + 8'd1;
    hr_pm     = (hr_inc >= 8'd12);
    hr_12val  = hr_pm ? hr_inc - 8'd12 : hr_inc;
    if (hr_12val == 8'd0) hr_12val = 8'd12;
    hr_12enc  = from_bin(hr_12val, bcd_i);
    hr_nx     = h24_i ? from_bin(hr_inc, bcd_i) : {hr_pm, hr_12enc[6:0]};
  end

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    hr_d  = hr_q;
    if (step_i) begin
      sec_d = sec_nx;
      if (sec_wrap) begin
        min_d = min_nx;
        if (min_wrap) hr_d = hr_nx;
      end
    end
    if (ld_go_i) begin
      case (ld_sel_i)
        FLD_SEC:  sec_d = ld_data_i;
        FLD_MIN:  min_d = ld_data_i;
        FLD_HOUR: hr_d  = ld_data_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
      hr_q  <= hr_d;
    end
  end

  assign day_step_o = step_i & sec_wrap & min_wrap & hr_wrap;
  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hr_q;

  // R2: minutes move only on a seconds rollover or a load
  p_min_on_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(step_i && sec_wrap) && !ld_go_i) |=> $stable(min_q));

  // R5: 11 AM advancing in 12-hour format lands in PM
  p_pm_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !h24_i && sec_wrap && min_wrap && hr_num == 8'd11) |=> hr_q[7]);
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
#(
  parameter logic [FIELD_W-1:0] RST_WDAY = 8'h01,
  parameter logic [FIELD_W-1:0] RST_YEAR = 8'h08,
  parameter logic [FIELD_W-1:0] RST_CENT = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               day_step_i,
  input  logic               bcd_i,
  input  logic               ld_go_i,
  input  fld_e               ld_sel_i,
  input  logic [FIELD_W-1:0] ld_data_i,
  output logic [FIELD_W-1:0] wday_o,
  output logic [FIELD_W-1:0] mday_o,
  output logic [FIELD_W-1:0] mon_o,
  output logic [FIELD_W-1:0] year_o,
  output logic [FIELD_W-1:0] cent_o,
  output logic [FIELD_W-1:0] cent2_o
);
  logic [FIELD_W-1:0] wday_q, wday_d, mday_q, mday_d, mon_q, mon_d;
  logic [FIELD_W-1:0] year_q, year_d, cent_q, cent_d, cent2_q, cent2_d;
  logic [FIELD_W-1:0] wday_nx, mday_nx, mon_nx, year_nx, cent_nx;
  logic               wday_wrap, mday_wrap, mon_wrap, year_wrap, cent_wrap;
  logic [FIELD_W-1:0] mday_last, last_99;

  assign mday_last = from_bin(month_days(to_bin(mon_q, bcd_i)), bcd_i);
  assign last_99   = from_bin(8'd99, bcd_i);

  rtc_step_field #(.W(FIELD_W)) u_wday (
    .cur_i(wday_q), .bcd_i(bcd_i), .first_i(8'd0), .last_i(8'd6),
    .next_o(wday_nx), .wrap_o(wday_wrap));

  rtc_step_field #(.W(FIELD_W)) u_mday (
    .cur_i(mday_q), .bcd_i(bcd_i), .first_i(8'd1), .last_i(mday_last),
    .next_o(mday_nx), .wrap_o(mday_wrap));

  rtc_step_field #(.W(FIELD_W)) u_mon (
    .cur_i(mon_q), .bcd_i(bcd_i), .first_i(8'd1), .last_i(from_bin(8'd12, bcd_i)),
    .next_o(mon_nx), .wrap_o(mon_wrap));

  rtc_step_field #(.W(FIELD_W)) u_year (
    .cur_i(year_q), .bcd_i(bcd_i), .first_i(8'd0), .last_i(last_99),
    .next_o(year_nx), .wrap_o(year_wrap));

  rtc_step_field #(.W(FIELD_W)) u_cent (
    .cur_i(cent_q), .bcd_i(bcd_i), .first_i(8'd0), .last_i(last_99),
    .next_o(cent_nx), .wrap_o(cent_wrap));

  always_comb begin
    wday_d  = wday_q;
    mday_d  = mday_q;
    mon_d   = mon_q;
    year_d  = year_q;
    cent_d  = cent_q;
    cent2_d = cent2_q;
    if (day_step_i) begin
      wday_d = wday_nx;
      mday_d = mday_nx;
      if (mday_wrap) begin
        mon_d = mon_nx;
        if (mon_wrap) begin
          year_d = year_nx;
          if (year_wrap) begin
            cent_d  = cent_nx;
            cent2_d = cent_nx;
          end
        end
      end
    end
    if (ld_go_i) begin
      case (ld_sel_i)
        FLD_WDAY: wday_d = ld_data_i;
        FLD_MDAY: mday_d = ld_data_i;
        FLD_MON:  mon_d  = ld_data_i;
        FLD_YEAR: year_d = ld_data_i;
        FLD_CENT: begin
          cent_d  = ld_data_i;
          cent2_d = ld_data_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday_q  <= RST_WDAY;
      mday_q  <= 8'h01;
      mon_q   <= 8'h01;
      year_q  <= RST_YEAR;
      cent_q  <= RST_CENT;
      cent2_q <= RST_CENT;
    end else begin
      wday_q  <= wday_d;
      mday_q  <= mday_d;
      mon_q   <= mon_d;
      year_q  <= year_d;
      cent_q  <= cent_d;
      cent2_q <= cent2_d;
    end
  end

  assign wday_o  = wday_q;
  assign mday_o  = mday_q;
  assign mon_o   = mon_q;
  assign year_o  = year_q;
  assign cent_o  = cent_q;
  assign cent2_o = cent2_q;

  // R8: century copies never diverge
  p_cent_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cent_q == cent2_q);

  // R6: weekday 6 is followed by 0
  p_wday_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step_i && wday_q == 8'd6 && !ld_go_i) |=> wday_q == 8'd0);

  // R7: end of month returns the day to 1
  p_mday_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step_i && mday_wrap && !ld_go_i) |=> mday_q == 8'h01);
endmodule

// File: rtl/rtc_calendar_counter.sv
module rtc_calendar_counter
  import rtc_cal_pkg::*;
#(
  parameter logic [7:0] RST_WDAY = 8'h01,
  parameter logic [7:0] RST_YEAR = 8'h08,
  parameter logic [7:0] RST_CENT = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       bin_mode_i,
  input  logic       h24_i,
  input  logic       hold_i,
  input  logic       load_en_i,
  input  logic [2:0] load_sel_i,
  input  logic [7:0] load_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic [7:0] cent_o,
  output logic [7:0] cent2_o
);
  logic step, ld_go, bcd, day_step;
  fld_e sel;

  assign bcd   = ~bin_mode_i;
  assign step  = tick_i & ~hold_i;
  assign ld_go = load_en_i & hold_i;
  assign sel   = fld_e'(load_sel_i);

  rtc_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .step_i(step), .bcd_i(bcd), .h24_i(h24_i),
    .ld_go_i(ld_go), .ld_sel_i(sel), .ld_data_i(load_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_step_o(day_step));

  rtc_date_chain #(.RST_WDAY(RST_WDAY), .RST_YEAR(RST_YEAR), .RST_CENT(RST_CENT)) u_date (
    .clk(clk), .rst_n(rst_n), .day_step_i(day_step), .bcd_i(bcd),
    .ld_go_i(ld_go), .ld_sel_i(sel), .ld_data_i(load_data_i),
    .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
    .cent_o(cent_o), .cent2_o(cent2_o));

  // R9: without a counted tick or an accepted load nothing moves
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_i && !hold_i) && !(load_en_i && hold_i)) |=>
      ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(wday_o) &&
       $stable(mday_o) && $stable(mon_o) && $stable(year_o) && $stable(cent_o)));

  // R3: in binary mode a counted tick never leaves seconds at 60 or above
  p_bin_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !hold_i && bin_mode_i && sec_o < 8'd60) |=> sec_o < 8'd60);
endmodule

// File: tb/test_rtc_calendar_counter.sv
`timescale 1ns/100ps
module test_rtc_calendar_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, bin_mode_i = 1'b0, h24_i = 1'b1, hold_i = 1'b0;
  logic       load_en_i = 1'b0;
  logic [2:0] load_sel_i = 3'd0;
  logic [7:0] load_data_i = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, cent_o, cent2_o;

  always #2.5 clk = ~clk;

  rtc_calendar_counter i_rtc_calendar_counter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bin_mode_i(bin_mode_i), .h24_i(h24_i),
    .hold_i(hold_i), .load_en_i(load_en_i), .load_sel_i(load_sel_i),
    .load_data_i(load_data_i), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
    .cent_o(cent_o), .cent2_o(cent2_o));

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";
  int m [9];   // 0 sec,1 min,2 hour,3 wday,4 mday,5 mon,6 year,7 cent,8 cent2

  function automatic int dec(int b, bit bin);
    return bin ? b : ((b >> 4) * 10 + (b & 15));
  endfunction
  function automatic int enc(int v, bit bin);
    return bin ? v : (((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int mlen(int mo);
    if (mo == 2) return 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    bit b = bin_mode_i;
    int s, mi, h, pm, h12, d;
    s = dec(m[0], b) + 1;
    if (s < 60) begin m[0] = enc(s, b); return; end
    m[0] = 0;
    mi = dec(m[1], b) + 1;
    if (mi < 60) begin m[1] = enc(mi, b); return; end
    m[1] = 0;
    if (h24_i) h = dec(m[2], b);
    else begin
      h = dec(m[2] & 8'h7f, b);
      if (h == 12) h = 0;
      if (m[2] & 8'h80) h += 12;
    end
    h = (h + 1) % 24;
    if (h24_i) m[2] = enc(h, b);
    else begin
      pm = (h >= 12);
      h12 = h % 12;
      if (h12 == 0) h12 = 12;
      m[2] = enc(h12, b) | (pm << 7);
    end
    if (h != 0) return;
    m[3] = (dec(m[3], b) + 1) % 7;
    d = dec(m[4], b);
    if (d != mlen(dec(m[5], b))) begin m[4] = enc(d + 1, b); return; end
    m[4] = 1;
    d = dec(m[5], b);
    if (d != 12) begin m[5] = enc(d + 1, b); return; end
    m[5] = 1;
    d = dec(m[6], b);
    if (d != 99) begin m[6] = enc(d + 1, b); return; end
    m[6] = 0;
    d = dec(m[7], b);
    m[7] = enc((d == 99) ? 0 : d + 1, b);
    m[8] = m[7];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = '{0, 0, 0, 1, 1, 1, 8'h08, 8'h20, 8'h20};
    end else if (hold_i && load_en_i) begin
      m[load_sel_i] = load_data_i;
      if (load_sel_i == 3'd7) m[8] = load_data_i;
    end else if (tick_i && !hold_i) begin
      model_tick();
    end
  end

  // compare every field on each falling edge
  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] got [9];
      got = '{sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, cent_o, cent2_o};
      for (int i = 0; i < 9; i++) begin
        total++;
        if (int'(got[i]) != m[i]) begin
          bad++;
          $display("FAIL %s field %0d: actual %02h expected %02h", tag, i, got[i], m[i][7:0]);
        end
      end
    end
  end

  task automatic load(input int sel, input int val);
    @(negedge clk);
    hold_i = 1'b1; load_en_i = 1'b1; load_sel_i = sel[2:0]; load_data_i = val[7:0];
    @(negedge clk);
    load_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    hold_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_time(input int h, input int mi, input int s);
    load(0, s); load(1, mi); load(2, h);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    tag = "R2"; bin_mode_i = 1'b0; h24_i = 1'b1;
    set_time(8'h09, 8'h58, 8'h07);
    ticks(5);                            // 07->08->09->10 digit carry
    set_time(8'h09, 8'h58, 8'h58);
    ticks(3);                            // sec wrap, minute carry
    set_time(8'h09, 8'h59, 8'h59);
    ticks(1);                            // minute wrap into hour

    tag = "R4"; set_time(8'h23, 8'h59, 8'h58);
    ticks(3);

    tag = "R5"; h24_i = 1'b0;
    set_time(8'h11, 8'h59, 8'h59); ticks(1);   // 11 AM -> 12 PM
    set_time(8'h92, 8'h59, 8'h59); ticks(1);   // 12 PM -> 1 PM
    set_time(8'h91, 8'h59, 8'h59); ticks(1);   // 11 PM -> 12 AM, day carry
    set_time(8'h12, 8'h59, 8'h59); ticks(1);   // 12 AM -> 1 AM
    h24_i = 1'b1;

    tag = "R6"; load(3, 6); set_time(8'h23, 8'h59, 8'h59); ticks(1);

    tag = "R7";
    load(5, 8'h02); load(4, 8'h28); set_time(8'h23, 8'h59, 8'h59); ticks(1);
    load(5, 8'h04); load(4, 8'h30); set_time(8'h23, 8'h59, 8'h59); ticks(1);
    load(5, 8'h01); load(4, 8'h29); set_time(8'h23, 8'h59, 8'h59); ticks(1);
    load(4, 8'h30); set_time(8'h23, 8'h59, 8'h59); ticks(1);
    set_time(8'h23, 8'h59, 8'h59); ticks(1);

    tag = "R8";
    load(5, 8'h12); load(4, 8'h31); load(6, 8'h41); set_time(8'h23, 8'h59, 8'h59); ticks(1);
    load(5, 8'h12); load(4, 8'h31); load(6, 8'h99); load(7, 8'h20);
    set_time(8'h23, 8'h59, 8'h59); ticks(1);

    tag = "R3"; bin_mode_i = 1'b1;
    load(3, 2); load(4, 31); load(5, 12); load(6, 99); load(7, 20);
    set_time(5, 10, 8); ticks(3);                 // 9 -> 0x0A
    set_time(23, 59, 58); ticks(2);               // full rollover in binary
    load(5, 2); load(4, 28); set_time(23, 59, 59); ticks(1);
    bin_mode_i = 1'b0;

    tag = "R10";
    for (int f = 0; f < 8; f++) load(f, 8'h10 + f);

    tag = "R9";
    @(negedge clk); hold_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick_i = 1'b1; @(negedge clk); tick_i = 1'b0; @(negedge clk);
    end
    hold_i = 1'b0; load_en_i = 1'b1; load_sel_i = 3'd4; load_data_i = 8'h77;
    @(negedge clk); load_en_i = 1'b0;
    @(negedge clk);
    ticks(2);
    repeat (2) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule